// File: doc/BRIEF.md
# TLB Entry Permission Checker

This block takes a translation entry that a lookup has already matched and decides whether the requested access may use it. Each entry covers a pair of adjacent pages, an even one and an odd one, and each half has its own attributes and physical page number. The block works out the page size, picks the half addressed by the virtual address, and runs five fault checks in a fixed priority. It returns one result code. When the access is allowed, it also returns the physical address and the read, write and execute permissions.

Requests arrive with a single valid strobe, and results leave one clock later through one register stage. The privilege check has two modes. In the default mode, a lower-privileged caller may not use a more privileged page. In the restricted mode, the caller's level must equal the page's level exactly. In 32-bit mode the inhibit bits and the restricted-mode bit of the entry are ignored. Before the page number is used, its software bits between bit 12 and the page size are removed.

Top module: `tlb_perm_check`

## Requirements
- R1: The page size is `in_entry_ps` when `in_fa_entry` is 1, and `in_global_ps` when it is 0. Valid page sizes run from 12 to VA_W-1.
- R2: Virtual address bit [page size] selects the half. 0 selects the even half and 1 selects the odd half. The per-half two-bit ports (`in_v`, `in_d`, `in_nx`, `in_nr`, `in_rplv`) carry the even half in bit 0 and the odd half in bit 1.
- R3: `in_access` is encoded as 0 = fetch, 1 = load and 2 = store. The checks run in this priority, and only the first failing one is reported:
  - not valid (code 1);
  - execute-inhibit on a fetch (code 2);
  - read-inhibit on a load (code 3);
  - privilege (code 4);
  - not dirty on a store (code 5).
  Code 0 means the access is allowed.
- R4: When the selected half's restricted bit is 0, a privilege fault occurs if `in_plv` is numerically greater than the half's level. When the bit is 1, a privilege fault occurs if `in_plv` differs from the half's level.
- R5: When `in_wide` is 0, the execute-inhibit, read-inhibit and restricted bits are treated as 0.
- R6: On a match, the page number bits for address bits 12 up to page size - 1 are cleared. `out_paddr` is the resulting page number shifted left by 12, ORed with the low page-size bits of the virtual address.
- R7: On a match, `out_perm` is set as follows:
  - bit 0 (read) is always 1;
  - bit 1 (write) equals the dirty bit;
  - bit 2 (execute) is the inverse of the effective execute-inhibit bit.
- R8: `out_valid` equals `in_valid` of the previous clock. A synchronous active-high `rst` clears `out_valid`, and it has priority over `in_valid`.
- R9: When the result code is not 0, `out_paddr` and `out_perm` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_vaddr | input | VA_W | Virtual address |
| in_access | input | 2 | 0 fetch, 1 load, 2 store |
| in_plv | input | 2 | Current privilege level |
| in_wide | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| in_fa_entry | input | 1 | Entry comes from the fully associative section |
| in_entry_ps | input | PS_W | Page size held in the entry |
| in_global_ps | input | PS_W | Global set-associative page size |
| in_v | input | 2 | Valid bits, bit 0 even, bit 1 odd |
| in_d | input | 2 | Dirty bits |
| in_nx | input | 2 | Execute-inhibit bits |
| in_nr | input | 2 | Read-inhibit bits |
| in_rplv | input | 2 | Restricted-privilege bits |
| in_eplv_even | input | 2 | Privilege level of even half |
| in_eplv_odd | input | 2 | Privilege level of odd half |
| in_ppn_even | input | PA_W-12 | Page number of even half |
| in_ppn_odd | input | PA_W-12 | Page number of odd half |
| out_valid | output | 1 | Result strobe |
| out_code | output | 3 | Result code |
| out_paddr | output | PA_W | Physical address on match |
| out_perm | output | 3 | {execute, write, read} on match |

## Verification
The bench builds the block with VA_W = 20, PA_W = 20 and PS_W = 6, so the page number is only 8 bits wide and the page size runs from 12 to 19. At this size the bench can sweep every combination of:
- access type;
- both privilege levels;
- the five attribute bits;
- the mode flag.

It can also try every page size with both page-size sources and both halves, so that each clearing width from 0 to 7 bits is reached. To catch a wrong half or a wrong size source, the unselected half is made invalid and the unused page-size input is set to a different value.

// File: rtl/tlb_perm_pkg.sv
package tlb_perm_pkg;

  localparam int PLV_W      = 2;
  localparam int PAGE_SHIFT = 12;
  localparam int CODE_W     = 3;
  localparam int PERM_W     = 3;

  typedef enum logic [CODE_W-1:0] {
    RES_MATCH   = 3'd0,
    RES_INVALID = 3'd1,
    RES_NOEXEC  = 3'd2,
    RES_NOREAD  = 3'd3,
    RES_PRIV    = 3'd4,
    RES_DIRTY   = 3'd5
  } result_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_OTHER = 2'd3
  } access_e;

  // Attributes of one half after mode masking
  typedef struct packed {
    logic             v;
    logic             d;
    logic             nx;
    logic             nr;
    logic             rplv;
    logic [PLV_W-1:0] plv;
  } half_attr_t;

endpackage

// File: rtl/tlb_perm_half_sel.sv
module tlb_perm_half_sel
  import tlb_perm_pkg::*;
#(
  parameter int VA_W  = 48,
  parameter int PPN_W = 36,
  parameter int PS_W  = 6
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic             wide,
  input  logic             fa_entry,
  input  logic [PS_W-1:0]  entry_ps,
  input  logic [PS_W-1:0]  global_ps,
  input  logic [1:0]       v,
  input  logic [1:0]       d,
  input  logic [1:0]       nx,
  input  logic [1:0]       nr,
  input  logic [1:0]       rplv,
  input  logic [PLV_W-1:0] eplv_even,
  input  logic [PLV_W-1:0] eplv_odd,
  input  logic [PPN_W-1:0] ppn_even,
  input  logic [PPN_W-1:0] ppn_odd,
  output logic [PS_W-1:0]  page_size,
  output logic             odd_sel,
  output half_attr_t       sel_attr,
  output logic [PPN_W-1:0] sel_ppn
);

  localparam int HALVES = 2;

  // Address bit at the page-size position picks the half
  function automatic logic pick_half(input logic [VA_W-1:0] va,
                                     input logic [PS_W-1:0] ps);
    logic [VA_W-1:0] shifted;
    shifted = va >> ps;
    return shifted[0];
  endfunction

  half_attr_t             attr_h [HALVES];
  logic [PLV_W-1:0]       plv_h  [HALVES];
  logic [PPN_W-1:0]       ppn_h  [HALVES];

  assign plv_h[0] = eplv_even;
  assign plv_h[1] = eplv_odd;
  assign ppn_h[0] = ppn_even;
  assign ppn_h[1] = ppn_odd;

  for (genvar g = 0; g < HALVES; g++) begin : g_half
    // 32-bit mode forces the 64-bit-only attributes to zero
    assign attr_h[g].v    = v[g];
    assign attr_h[g].d    = d[g];
    assign attr_h[g].nx   = wide & nx[g];
    assign attr_h[g].nr   = wide & nr[g];
    assign attr_h[g].rplv = wide & rplv[g];
    assign attr_h[g].plv  = plv_h[g];
  end

  assign page_size = fa_entry ? entry_ps : global_ps;
  assign odd_sel   = pick_half(vaddr, page_size);
  assign sel_attr  = odd_sel ? attr_h[1] : attr_h[0];
  assign sel_ppn   = odd_sel ? ppn_h[1]  : ppn_h[0];

endmodule

// File: rtl/tlb_perm_rights.sv
module tlb_perm_rights
  import tlb_perm_pkg::*;
(
  input  half_attr_t       attr,
  input  access_e          access,
  input  logic [PLV_W-1:0] cur_plv,
  output logic             priv_fault,
  output result_e          code
);

  // Default mode: caller may not be less privileged (higher number)
  // Restricted mode: caller level must equal the page level
  function automatic logic priv_violates(input logic [PLV_W-1:0] cur,
                                         input logic [PLV_W-1:0] ent,
                                         input logic             restricted);
    if (restricted) return cur != ent;
    return cur > ent;
  endfunction

  logic fetch_blocked;
  logic load_blocked;
  logic store_blocked;

  assign priv_fault    = priv_violates(cur_plv, attr.plv, attr.rplv);
  assign fetch_blocked = (access == ACC_FETCH) && attr.nx;
  assign load_blocked  = (access == ACC_LOAD)  && attr.nr;
  assign store_blocked = (access == ACC_STORE) && !attr.d;

  // Fixed priority: first failing check wins
  always_comb begin
    if (!attr.v)            code = RES_INVALID;
    else if (fetch_blocked) code = RES_NOEXEC;
    else if (load_blocked)  code = RES_NOREAD;
    else if (priv_fault)    code = RES_PRIV;
    else if (store_blocked) code = RES_DIRTY;
    else                    code = RES_MATCH;
  end

endmodule

// File: rtl/tlb_perm_xlate.sv
module tlb_perm_xlate
  import tlb_perm_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PA_W = 48,
  parameter int PS_W = 6
) (
  input  logic [VA_W-1:0]         vaddr,
  input  logic [PA_W-PAGE_SHIFT-1:0] ppn,
  input  logic [PS_W-1:0]         page_size,
  input  logic                    dirty,
  input  logic                    nx,
  output logic [PA_W-1:0]         paddr,
  output logic [PERM_W-1:0]       perm
);

  localparam int PPN_W = PA_W - PAGE_SHIFT;
  localparam int WW    = (VA_W > PA_W) ? VA_W : PA_W;

  // Drop page-number bits that fall inside the page offset
  function automatic logic [PPN_W-1:0] clear_sw_bits(input logic [PPN_W-1:0] p,
                                                    input logic [PS_W-1:0]  ps);
    int              cnt;
    logic [PPN_W-1:0] keep;
    cnt  = (int'(ps) > PAGE_SHIFT) ? int'(ps) - PAGE_SHIFT : 0;
    keep = '1;
    keep = keep << cnt;
    return p & keep;
  endfunction

  // Keep only the in-page offset of the virtual address
  function automatic logic [VA_W-1:0] page_offset(input logic [VA_W-1:0] va,
                                                  input logic [PS_W-1:0] ps);
    logic [VA_W-1:0] hi;
    hi = '1;
    hi = hi << ps;
    return va & ~hi;
  endfunction

  logic [PPN_W-1:0] ppn_clean;
  logic [WW-1:0]    offset_ext;

  assign ppn_clean  = clear_sw_bits(ppn, page_size);
  assign offset_ext = WW'(page_offset(vaddr, page_size));
  assign paddr      = {ppn_clean, {PAGE_SHIFT{1'b0}}} | offset_ext[PA_W-1:0];
  assign perm       = {~nx, dirty, 1'b1};

endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
  import tlb_perm_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PA_W = 48,
  parameter int PS_W = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [VA_W-1:0]            in_vaddr,
  input  logic [1:0]                 in_access,
  input  logic [1:0]                 in_plv,
  input  logic                       in_wide,
  input  logic                       in_fa_entry,
  input  logic [PS_W-1:0]            in_entry_ps,
  input  logic [PS_W-1:0]            in_global_ps,
  input  logic [1:0]                 in_v,
  input  logic [1:0]                 in_d,
  input  logic [1:0]                 in_nx,
  input  logic [1:0]                 in_nr,
  input  logic [1:0]                 in_rplv,
  input  logic [1:0]                 in_eplv_even,
  input  logic [1:0]                 in_eplv_odd,
  input  logic [PA_W-PAGE_SHIFT-1:0] in_ppn_even,
  input  logic [PA_W-PAGE_SHIFT-1:0] in_ppn_odd,
  output logic                       out_valid,
  output logic [CODE_W-1:0]          out_code,
  output logic [PA_W-1:0]            out_paddr,
  output logic [PERM_W-1:0]          out_perm
);

  localparam int PPN_W = PA_W - PAGE_SHIFT;

  // Named internal events
  logic [PS_W-1:0]  page_size;
  logic             odd_sel;
  half_attr_t       sel_attr;
  logic [PPN_W-1:0] sel_ppn;
  logic             priv_fault;
  result_e          code_c;
  logic [PA_W-1:0]  paddr_c;
  logic [PERM_W-1:0] perm_c;
  logic             is_match;

  tlb_perm_half_sel #(.VA_W(VA_W), .PPN_W(PPN_W), .PS_W(PS_W)) u_half (
    .vaddr     (in_vaddr),
    .wide      (in_wide),
    .fa_entry  (in_fa_entry),
    .entry_ps  (in_entry_ps),
    .global_ps (in_global_ps),
    .v         (in_v),
    .d         (in_d),
    .nx        (in_nx),
    .nr        (in_nr),
    .rplv      (in_rplv),
    .eplv_even (in_eplv_even),
    .eplv_odd  (in_eplv_odd),
    .ppn_even  (in_ppn_even),
    .ppn_odd   (in_ppn_odd),
    .page_size (page_size),
    .odd_sel   (odd_sel),
    .sel_attr  (sel_attr),
    .sel_ppn   (sel_ppn)
  );

  tlb_perm_rights u_rights (
    .attr       (sel_attr),
    .access     (access_e'(in_access)),
    .cur_plv    (in_plv),
    .priv_fault (priv_fault),
    .code       (code_c)
  );

  tlb_perm_xlate #(.VA_W(VA_W), .PA_W(PA_W), .PS_W(PS_W)) u_xlate (
    .vaddr     (in_vaddr),
    .ppn       (sel_ppn),
    .page_size (page_size),
    .dirty     (sel_attr.d),
    .nx        (sel_attr.nx),
    .paddr     (paddr_c),
    .perm      (perm_c)
  );

  assign is_match = (code_c == RES_MATCH);

  // Single register stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
      out_paddr <= '0;
      out_perm  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_code  <= code_c;
        out_paddr <= is_match ? paddr_c : '0;
        out_perm  <= is_match ? perm_c  : '0;
      end
    end
  end

  // R8: result strobe tracks request strobe one clock later
  p_valid_follow_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_follow_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R3: an invalid selected half always reports code 1
  p_invalid_first_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sel_attr.v) |=> (out_code == RES_INVALID));

  // R4: a privilege fault with no earlier fault reports code 4
  p_priv_code_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel_attr.v && !sel_attr.nx && !sel_attr.nr && priv_fault)
      |=> (out_code == RES_PRIV));

  // R5: narrow mode never produces inhibit faults
  p_narrow_no_inhibit_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_wide) |=> (out_code != RES_NOEXEC && out_code != RES_NOREAD));

  // R7: read always granted on a match, write follows dirty
  p_read_always_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_code == RES_MATCH) |-> out_perm[0]);
  p_write_dirty_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_match) |=> (out_perm[1] == $past(sel_attr.d)));

  // R9: faults carry no address and no permission
  p_fault_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_code != RES_MATCH) |-> (out_paddr == '0 && out_perm == '0));

endmodule

// File: tb/test_tlb_perm_check.sv
module test_tlb_perm_check;

  localparam int VA_W = 20;
  localparam int PA_W = 20;
  localparam int PS_W = 6;
  localparam int PPN_W = PA_W - 12;

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid;
  logic [VA_W-1:0]  in_vaddr;
  logic [1:0]       in_access;
  logic [1:0]       in_plv;
  logic             in_wide;
  logic             in_fa_entry;
  logic [PS_W-1:0]  in_entry_ps;
  logic [PS_W-1:0]  in_global_ps;
  logic [1:0]       in_v, in_d, in_nx, in_nr, in_rplv;
  logic [1:0]       in_eplv_even, in_eplv_odd;
  logic [PPN_W-1:0] in_ppn_even, in_ppn_odd;
  logic             out_valid;
  logic [2:0]       out_code;
  logic [PA_W-1:0]  out_paddr;
  logic [2:0]       out_perm;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tlb_perm_check #(.VA_W(VA_W), .PA_W(PA_W), .PS_W(PS_W)) i_tlb_perm_check (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_vaddr(in_vaddr),
    .in_access(in_access), .in_plv(in_plv), .in_wide(in_wide),
    .in_fa_entry(in_fa_entry), .in_entry_ps(in_entry_ps),
    .in_global_ps(in_global_ps), .in_v(in_v), .in_d(in_d), .in_nx(in_nx),
    .in_nr(in_nr), .in_rplv(in_rplv), .in_eplv_even(in_eplv_even),
    .in_eplv_odd(in_eplv_odd), .in_ppn_even(in_ppn_even),
    .in_ppn_odd(in_ppn_odd), .out_valid(out_valid), .out_code(out_code),
    .out_paddr(out_paddr), .out_perm(out_perm)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected code from the priority rules
  function automatic int model_code(int acc, int plv, int ep, bit v, bit d,
                                    bit nx, bit nr, bit rp, bit wide);
    bit enx = wide && nx;
    bit enr = wide && nr;
    bit erp = wide && rp;
    if (!v) return 1;
    if (acc == 0 && enx) return 2;
    if (acc == 1 && enr) return 3;
    if ((!erp && plv > ep) || (erp && plv != ep)) return 4;
    if (acc == 2 && !d) return 5;
    return 0;
  endfunction

  // Present inputs, let one edge register them, sample after the edge
  task automatic step();
    in_valid = 1'b1;
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_vaddr = '0; in_access = 2'd1; in_plv = 2'd0;
    in_wide = 1'b1; in_fa_entry = 1'b0; in_entry_ps = 6'd12; in_global_ps = 6'd12;
    in_v = 2'b00; in_d = 2'b00; in_nx = 2'b00; in_nr = 2'b00; in_rplv = 2'b00;
    in_eplv_even = 2'd0; in_eplv_odd = 2'd0; in_ppn_even = '0; in_ppn_odd = '0;
    repeat (3) @(posedge clk);
    #2;
    check("R8 reset out_valid", int'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;

    // Sweep A: all attributes, levels and access types on the even half
    for (int acc = 0; acc < 3; acc++)
      for (int plv = 0; plv < 4; plv++)
        for (int ep = 0; ep < 4; ep++)
          for (int b = 0; b < 64; b++) begin
            bit v = b[0], d = b[1], nx = b[2], nr = b[3], rp = b[4], wd = b[5];
            int ec, eperm, epa;
            in_vaddr = 20'h32ABC;        // bit 12 = 0 selects even
            in_global_ps = 6'd12; in_entry_ps = 6'd15; in_fa_entry = 1'b0;
            in_access = 2'(acc); in_plv = 2'(plv); in_wide = wd;
            in_v = {~v, v}; in_d = {~d, d}; in_nx = {~nx, nx};
            in_nr = {~nr, nr}; in_rplv = {~rp, rp};
            in_eplv_even = 2'(ep); in_eplv_odd = 2'(3 - ep);
            in_ppn_even = 8'hA5; in_ppn_odd = 8'h3C;
            ec = model_code(acc, plv, ep, v, d, nx, nr, rp, wd);
            eperm = (ec == 0) ? (1 + (d ? 2 : 0) + ((wd && nx) ? 0 : 4)) : 0;
            epa = (ec == 0) ? 'hA5ABC : 0;
            step();
            check("R3 R4 R5 code", int'(out_code), ec);
            check("R7 R9 perm", int'(out_perm), eperm);
            check("R6 R9 paddr", int'(out_paddr), epa);
            check("R8 out_valid", int'(out_valid), 1);
            @(negedge clk);
          end

    // Sweep B: page sizes, size source and half selection
    for (int ps = 12; ps < 20; ps++)
      for (int fa = 0; fa < 2; fa++)
        for (int odd = 0; odd < 2; odd++)
          for (int k = 0; k < 4; k++) begin
            int other = 12 + ((ps - 12 + 3) % 8);
            int va, pe, po, psel, cnt, epa;
            va = (k * 'h9E37 + ps * 'h1357) & 'hFFFFF;
            va = odd ? (va | (1 << ps)) : (va & ~(1 << ps));
            pe = ('h35 + k * 'h11) & 'h7F;
            po = pe | 'h80;
            in_vaddr = 20'(va);
            in_fa_entry = fa[0];
            in_entry_ps = 6'(fa ? ps : other);
            in_global_ps = 6'(fa ? other : ps);
            in_access = 2'd2; in_plv = 2'd1; in_wide = 1'b1;
            in_v = odd ? 2'b10 : 2'b01; in_d = 2'b11;
            in_nx = 2'b00; in_nr = 2'b00; in_rplv = 2'b00;
            in_eplv_even = 2'd3; in_eplv_odd = 2'd3;
            in_ppn_even = 8'(pe); in_ppn_odd = 8'(po);
            psel = odd ? po : pe;
            cnt = ps - 12;
            epa = (((psel >> cnt) << cnt) * 4096 + (va % (1 << ps))) % (1 << 20);
            step();
            check("R1 R2 code", int'(out_code), 0);
            check("R6 paddr", int'(out_paddr), epa);
            check("R7 perm", int'(out_perm), 7);
            @(negedge clk);
          end

    // R8: idle cycle drops the strobe
    in_valid = 1'b0;
    @(posedge clk);
    #2;
    check("R8 idle out_valid", int'(out_valid), 0);
    @(negedge clk);
    // R8: reset wins over a request
    rst = 1'b1;
    step();
    check("R8 reset priority", int'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule